// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It does this by reading two entries from a page table held in memory. A request brings a linear address, an access kind (read or write) and a privilege level (user or supervisor). The walker takes the page-directory frame from a base input and reads the directory entry. That entry names the frame of a page table, and the walker then reads the table entry. The table entry names the 4 KB physical frame, and the 12-bit page offset is appended to it to form the physical address.

There is one memory read port. It uses a level request with an address and a one-cycle return strobe that comes with the data. Each walk ends in one of two ways:
- a one-cycle response carrying the physical address and the combined rights, or
- a page fault with a cause code, which also latches the faulting linear address into a fault-address register.

When paging is disabled, the linear address passes straight through and no memory read is made. Only one walk can be in flight; the block signals busy for the whole walk.

The controller has five named states:
- IDLE
- FETCH_PDE (directory read)
- FETCH_PTE (table read)
- DONE (success response)
- FAULT (fault response)

The transitions are:
- IDLE→FETCH_PDE on an accepted request with paging on.
- IDLE→DONE on an accepted request with paging off.
- FETCH_PDE→FETCH_PTE on a returned entry that is present.
- FETCH_PDE→FAULT on a returned entry that is not present.
- FETCH_PTE→DONE on a returned entry that passes all checks.
- FETCH_PTE→FAULT on a returned entry that fails any check.
- DONE→IDLE and FAULT→IDLE unconditionally.

Top module: `pgwalk_top`

## Requirements
- R1: A request is accepted at a clock edge where `req_valid` is high and the walker is idle. `busy` is high from the cycle after acceptance through the response cycle, and is low in the cycle after the response. While `busy` is high, request inputs are ignored: a changed address, access kind or privilege during a walk does not alter that walk's response.
- R2: If `paging_on` is low at acceptance, `rsp_valid` rises in the first cycle after acceptance. In that response `rsp_paddr` equals the linear address, `rsp_writable`=1, `rsp_user`=1 and `rsp_fault`=0, and no memory read is issued.
- R3: With paging on, the first read goes to address {`dir_base`, linear[31:22], 2'b00}. `dir_base` is the 20-bit directory frame number and is sampled at acceptance, so later changes to it have no effect on the walk.
- R4: The second read goes to address {directory entry[31:12], linear[21:12], 2'b00}.
- R5: On success, `rsp_paddr` = {table entry[31:12], linear[11:0]}. `rsp_writable` is the AND of bit 1 of the two entries, and `rsp_user` is the AND of bit 2 of the two entries.
- R6: Bit 0 of an entry is the present bit. If the directory entry has bit 0 clear, the walk faults with code 1 after exactly one read. If the table entry has bit 0 clear, the walk faults with code 1.
- R7: A user access (`req_user`=1) faults with code 2 when the combined user bit is 0. Otherwise, a write (`req_write`=1) faults with code 3 when the combined writable bit is 0. This applies to supervisor writes as well. The priority is code 1, then 2, then 3.
- R8: `fault_addr` is 0 after reset. It takes the linear address of a faulting walk in that walk's response cycle, and otherwise holds its value.
- R9: `mem_rd_req` is only high while `busy` is high. It stays high, with `mem_rd_addr` stable and 4-byte aligned, until the cycle in which `mem_rd_valid` is high.
- R10: `rsp_valid` is a one-cycle pulse. `rsp_fault` is high in a fault response. `rsp_code` is 0 on success and 1, 2 or 3 on a fault, so `rsp_fault` is high exactly when `rsp_code` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| paging_on | input | 1 | Translation enable; 0 passes the address through |
| dir_base | input | 20 | Frame number of the page directory |
| busy | output | 1 | Walk in progress; requests are not accepted |
| mem_rd_req | output | 1 | Memory read request, held until data returns |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data valid strobe |
| mem_rd_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (meaningful on success) |
| rsp_writable | output | 1 | Combined writable right |
| rsp_user | output | 1 | Combined user right |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_code | output | 2 | 0 ok, 1 not present, 2 privilege, 3 write protect |
| fault_addr | output | 32 | Linear address of the most recent fault |

## Verification
The bench builds the walker with its default widths: a 32-bit address and a 12-bit offset, which give 10-bit directory and table indices. With these widths the random linear addresses and directory frames reach every index. The bench models memory as a sparse word map that is filled by a hash, with directed entries laid over it. Memory latency varies from zero to two wait cycles, so the hold of `mem_rd_addr` and the capture of `dir_base` at acceptance are both exercised. The directed entries set up the corner cases: each level not present, rights that differ between the two levels, the order of precedence among the fault codes, and request inputs that change in the middle of a walk.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    // Walk controller states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PDE   = 3'd1,
        ST_PTE   = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } walk_state_e;

    // Fault cause, lowest nonzero value wins
    typedef enum logic [1:0] {
        FC_NONE    = 2'd0,
        FC_NOTPRES = 2'd1,
        FC_PRIV    = 2'd2,
        FC_WPROT   = 2'd3
    } fault_code_e;

    // Entry flag positions
    localparam int FLAG_P = 0;
    localparam int FLAG_W = 1;
    localparam int FLAG_U = 2;

endpackage

// File: rtl/pgwalk_addr.sv
// Forms the byte address of the directory or table entry.
module pgwalk_addr #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic                    leaf,
    input  logic [ADDR_W-OFF_W-1:0] dir_frame,
    input  logic [ADDR_W-OFF_W-1:0] tbl_frame,
    input  logic [ADDR_W-1:0]       vaddr,
    output logic [ADDR_W-1:0]       entry_addr
);
    localparam int IDX_W = OFF_W - 2;
    localparam int TBL_LO = OFF_W;
    localparam int DIR_LO = OFF_W + IDX_W;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;

    always_comb begin
        dir_idx = vaddr[DIR_LO +: IDX_W];
        tbl_idx = vaddr[TBL_LO +: IDX_W];
        if (leaf) begin
            entry_addr = {tbl_frame, tbl_idx, 2'b00};
        end else begin
            entry_addr = {dir_frame, dir_idx, 2'b00};
        end
    end
endmodule

// File: rtl/pgwalk_rights.sv
// Judges a fetched entry: presence at either level, rights at the leaf.
module pgwalk_rights
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] entry,
    input  logic              leaf,
    input  logic              pde_w,
    input  logic              pde_u,
    input  logic              acc_write,
    input  logic              acc_user,
    output fault_code_e       code,
    output logic              eff_w,
    output logic              eff_u
);
    always_comb begin
        eff_w = pde_w & entry[FLAG_W];
        eff_u = pde_u & entry[FLAG_U];
        if (!entry[FLAG_P]) begin
            code = FC_NOTPRES;
        end else if (!leaf) begin
            code = FC_NONE;
        end else if (acc_user && !eff_u) begin
            code = FC_PRIV;
        end else if (acc_write && !eff_w) begin
            code = FC_WPROT;
        end else begin
            code = FC_NONE;
        end
    end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_vaddr,
    input  logic                    req_write,
    input  logic                    req_user,
    input  logic                    paging_on,
    input  logic [ADDR_W-OFF_W-1:0] dir_base,
    output logic                    busy,
    output logic                    mem_rd_req,
    output logic [ADDR_W-1:0]       mem_rd_addr,
    input  logic                    mem_rd_valid,
    input  logic [ADDR_W-1:0]       mem_rd_data,
    output logic                    rsp_valid,
    output logic [ADDR_W-1:0]       rsp_paddr,
    output logic                    rsp_writable,
    output logic                    rsp_user,
    output logic                    rsp_fault,
    output logic [1:0]              rsp_code,
    output logic [ADDR_W-1:0]       fault_addr
);
    localparam int FRAME_W = ADDR_W - OFF_W;

    walk_state_e state_q, state_d;

    logic [ADDR_W-1:0]  va_q;
    logic               wr_q, us_q;
    logic [FRAME_W-1:0] base_q, tbl_q;
    logic               pde_w_q, pde_u_q;
    logic [ADDR_W-1:0]  paddr_q, fault_addr_q;
    logic               res_w_q, res_u_q;
    fault_code_e        code_q;

    logic               accept, leaf, got_entry;
    fault_code_e        chk_code;
    logic               chk_w, chk_u;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign leaf      = (state_q == ST_PTE);
    assign got_entry = mem_rd_valid && ((state_q == ST_PDE) || (state_q == ST_PTE));

    pgwalk_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
        .leaf       (leaf),
        .dir_frame  (base_q),
        .tbl_frame  (tbl_q),
        .vaddr      (va_q),
        .entry_addr (mem_rd_addr)
    );

    pgwalk_rights #(.ADDR_W(ADDR_W)) u_rights (
        .entry     (mem_rd_data),
        .leaf      (leaf),
        .pde_w     (pde_w_q),
        .pde_u     (pde_u_q),
        .acc_write (wr_q),
        .acc_user  (us_q),
        .code      (chk_code),
        .eff_w     (chk_w),
        .eff_u     (chk_u)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = paging_on ? ST_PDE : ST_DONE;
            end
            ST_PDE: begin
                if (mem_rd_valid) state_d = (chk_code == FC_NONE) ? ST_PTE : ST_FAULT;
            end
            ST_PTE: begin
                if (mem_rd_valid) state_d = (chk_code == FC_NONE) ? ST_DONE : ST_FAULT;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Walk context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q         <= '0;
            wr_q         <= 1'b0;
            us_q         <= 1'b0;
            base_q       <= '0;
            tbl_q        <= '0;
            pde_w_q      <= 1'b0;
            pde_u_q      <= 1'b0;
            paddr_q      <= '0;
            res_w_q      <= 1'b0;
            res_u_q      <= 1'b0;
            code_q       <= FC_NONE;
            fault_addr_q <= '0;
        end else begin
            if (accept) begin
                va_q   <= req_vaddr;
                wr_q   <= req_write;
                us_q   <= req_user;
                base_q <= dir_base;
                code_q <= FC_NONE;
                if (!paging_on) begin
                    paddr_q <= req_vaddr;
                    res_w_q <= 1'b1;
                    res_u_q <= 1'b1;
                end
            end
            if (got_entry) begin
                code_q <= chk_code;
                if (chk_code != FC_NONE) fault_addr_q <= va_q;
                if (leaf) begin
                    paddr_q <= {mem_rd_data[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
                    res_w_q <= chk_w;
                    res_u_q <= chk_u;
                end else begin
                    tbl_q   <= mem_rd_data[ADDR_W-1:OFF_W];
                    pde_w_q <= mem_rd_data[FLAG_W];
                    pde_u_q <= mem_rd_data[FLAG_U];
                end
            end
        end
    end

    // Outputs
    always_comb begin
        busy         = (state_q != ST_IDLE);
        mem_rd_req   = (state_q == ST_PDE) || (state_q == ST_PTE);
        rsp_valid    = (state_q == ST_DONE) || (state_q == ST_FAULT);
        rsp_fault    = (state_q == ST_FAULT);
        rsp_code     = code_q;
        rsp_paddr    = paddr_q;
        rsp_writable = res_w_q;
        rsp_user     = res_u_q;
        fault_addr   = fault_addr_q;
    end
endmodule

// File: rtl/pgwalk_sva.sv
module pgwalk_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [1:0]        rsp_code,
    input logic [ADDR_W-1:0] fault_addr
);
    assert_rsp_then_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !busy);

    assert_no_read_at_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_rd_req);

    assert_fault_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_addr) |-> (rsp_valid && rsp_fault));

    assert_req_inside_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> busy);

    assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    assert_addr_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));

    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_code_agrees_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_code != 2'd0)));
endmodule

bind pgwalk_top pgwalk_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_code     (rsp_code),
    .fault_addr   (fault_addr)
);

// File: tb/pgwalk_top_test.sv
`timescale 1ns/1ps
module pgwalk_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        paging_on = 1'b0;
    logic [19:0] dir_base = '0;
    logic        busy, mem_rd_req, mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_addr, mem_rd_data = '0;
    logic        rsp_valid, rsp_writable, rsp_user, rsp_fault;
    logic [31:0] rsp_paddr, fault_addr;
    logic [1:0]  rsp_code;

    always #2.5 clk = ~clk;

    pgwalk_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .paging_on(paging_on),
        .dir_base(dir_base), .busy(busy), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_writable(rsp_writable), .rsp_user(rsp_user), .rsp_fault(rsp_fault),
        .rsp_code(rsp_code), .fault_addr(fault_addr)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Sparse memory: directed words override a hash fill
    logic [31:0] mem [logic [29:0]];

    function automatic logic [31:0] rd_word(logic [31:0] a);
        logic [31:0] x;
        if (mem.exists(a[31:2])) return mem[a[31:2]];
        x = a * 32'h9E3779B1;
        x = x ^ (x >> 15);
        x = x * 32'h85EBCA77;
        x = x ^ (x >> 13);
        return {x[31:1], x[0] | (x[5:4] != 2'b00)};
    endfunction

    // Memory responder: 0..2 wait cycles
    int unsigned wait_cnt = 0;
    always @(negedge clk) begin
        if (mem_rd_valid) begin
            mem_rd_valid <= 1'b0;
        end else if (mem_rd_req) begin
            if (wait_cnt == 0) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= rd_word(mem_rd_addr);
                wait_cnt     <= $urandom % 3;
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end
    end

    // Read trace
    int          nrd = 0;
    logic [31:0] rd_log [4];
    always @(posedge clk) begin
        if (mem_rd_req && mem_rd_valid) begin
            if (nrd < 4) rd_log[nrd] = mem_rd_addr;
            nrd = nrd + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pde_addr(logic [19:0] b, logic [31:0] va);
        return {b, va[31:22], 2'b00};
    endfunction
    function automatic logic [31:0] pte_addr(logic [31:0] pde, logic [31:0] va);
        return {pde[31:12], va[21:12], 2'b00};
    endfunction

    logic [31:0] exp_fa = '0;

    // One walk with reference model and checks
    task automatic walk(input logic [31:0] va, input logic wr, input logic us,
                        input logic pg, input logic [19:0] base, input bit intrude);
        logic [31:0] pde, pte, e_pa, a0, a1;
        logic        e_w, e_u;
        logic [1:0]  e_code;
        int          e_nrd, lat;
        logic [19:0] saved_base;
        e_pa = '0; e_w = 1'b0; e_u = 1'b0; e_code = 2'd0; a0 = '0; a1 = '0;
        if (!pg) begin
            e_nrd = 0; e_pa = va; e_w = 1'b1; e_u = 1'b1;
        end else begin
            a0  = pde_addr(base, va);
            pde = rd_word(a0);
            if (!pde[0]) begin
                e_nrd = 1; e_code = 2'd1;
            end else begin
                e_nrd = 2;
                a1  = pte_addr(pde, va);
                pte = rd_word(a1);
                e_w = pde[1] & pte[1];
                e_u = pde[2] & pte[2];
                if (!pte[0])          e_code = 2'd1;
                else if (us && !e_u)  e_code = 2'd2;
                else if (wr && !e_w)  e_code = 2'd3;
                e_pa = {pte[31:12], va[11:0]};
            end
        end
        if (e_code != 2'd0) exp_fa = va;

        @(negedge clk);
        nrd = 0;
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = us;
        paging_on = pg; dir_base = base;
        saved_base = base;
        @(negedge clk);
        chk("R1 busy after accept", {31'd0, busy}, 32'd1);
        if (intrude) begin
            req_vaddr = ~va; req_write = ~wr; req_user = ~us;
            dir_base = ~base; paging_on = ~pg;
        end else begin
            req_valid = 1'b0;
        end
        lat = 1;
        while (!rsp_valid && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        if (!pg) chk("R2 passthrough latency", lat, 1);
        chk("R10 response seen", {31'd0, rsp_valid}, 32'd1);
        chk("R7 R6 fault code", {30'd0, rsp_code}, {30'd0, e_code});
        chk("R10 fault flag", {31'd0, rsp_fault}, {31'd0, e_code != 2'd0});
        if (e_code == 2'd0) begin
            chk(pg ? "R5 paddr" : "R2 paddr", rsp_paddr, e_pa);
            chk("R5 writable", {31'd0, rsp_writable}, {31'd0, e_w});
            chk("R5 user", {31'd0, rsp_user}, {31'd0, e_u});
        end
        chk("R8 fault address", fault_addr, exp_fa);
        chk("R6 read count", nrd, e_nrd);
        if (e_nrd >= 1) chk("R3 directory read address", rd_log[0], a0);
        if (e_nrd >= 2) chk("R4 table read address", rd_log[1], a1);
        req_valid = 1'b0;
        dir_base = saved_base;
        @(negedge clk);
        chk("R1 idle after response", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_val;
        logic [19:0] b;
        logic [31:0] va;
        seed_val = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        chk("R8 reset fault address", fault_addr, 32'd0);
        chk("R1 reset busy", {31'd0, busy}, 32'd0);
        chk("R10 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R9 reset mem_rd_req", {31'd0, mem_rd_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: pass-through
        walk(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 20'h12345, 0);

        // Directed: directory entry not present
        b = 20'h00100; va = 32'h0040_1234;
        mem[pde_addr(b, va) >> 2] = 32'h0000_0006;
        walk(va, 1'b0, 1'b0, 1'b1, b, 0);

        // Directed: table entry not present
        va = 32'h0080_2345;
        mem[pde_addr(b, va) >> 2] = 32'h0020_0007;
        mem[pte_addr(32'h0020_0007, va) >> 2] = 32'hABCD_E006;
        walk(va, 1'b0, 1'b0, 1'b1, b, 0);

        // Directed: fault_addr holds over a successful walk
        va = 32'h00C0_3456;
        mem[pde_addr(b, va) >> 2] = 32'h0030_0007;
        mem[pte_addr(32'h0030_0007, va) >> 2] = 32'h5555_5007;
        walk(va, 1'b1, 1'b1, 1'b1, b, 0);

        // Directed: supervisor page, read-only, user write -> privilege wins
        va = 32'h0100_4567;
        mem[pde_addr(b, va) >> 2] = 32'h0040_0007;
        mem[pte_addr(32'h0040_0007, va) >> 2] = 32'h6666_6001;
        walk(va, 1'b1, 1'b1, 1'b1, b, 0);
        // same page: supervisor write -> write protect
        walk(va, 1'b1, 1'b0, 1'b1, b, 0);
        // same page: supervisor read -> success
        walk(va, 1'b0, 1'b0, 1'b1, b, 0);

        // Directed: directory denies user and write, table allows both
        va = 32'h0140_5678;
        mem[pde_addr(b, va) >> 2] = 32'h0050_0001;
        mem[pte_addr(32'h0050_0001, va) >> 2] = 32'h7777_7007;
        walk(va, 1'b0, 1'b1, 1'b1, b, 0);
        walk(va, 1'b1, 1'b0, 1'b1, b, 0);
        walk(va, 1'b0, 1'b0, 1'b1, b, 0);

        // Directed: inputs change during the walk (R1 ignore, R3 base capture)
        walk(32'h0080_2FFF, 1'b0, 1'b0, 1'b1, b, 1);
        walk(32'h00C0_3000, 1'b1, 1'b1, 1'b1, b, 1);
        walk(32'hCAFE_0123, 1'b1, 1'b0, 1'b0, 20'hFFFFF, 1);

        // Random walks
        for (int i = 0; i < 400; i++) begin
            walk($urandom, 1'($urandom), 1'($urandom), ($urandom % 8) != 0,
                 20'($urandom), ($urandom % 6) == 0);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule